// File: doc/BRIEF.md
# Poison-Tagged Register File with Deferred Fatal Exceptions

This block is a general-purpose register file in which every entry carries a one-bit poison tag. The tag lets the pipeline run instructions speculatively, ahead of the branches or stores that guard them, without taking their fatal faults too early. When a speculative instruction suffers a program-terminating fault, the fault is not raised. The destination register is marked poisoned instead. The fault becomes real only when a non-speculative consumer reads that register. Resumable faults, such as a missing page, are signalled at once whether or not the instruction is speculative, because servicing them costs only time.

A check port stands in for the test the compiler places at the instruction's original program position. It names one register and requests recovery when that register holds poison. Speculative consumers that read a poisoned source do not fault. The pipeline reports this on the write port, and the poison passes on to the destination. The file has one write port, a parameterised number of read ports and one check port. A write seen in the same cycle is forwarded to every read and check port. Register 0 always reads as a clean zero.

Top module: `poison_rf`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears every poison tag and every data word, so any read returns data 0 with poison 0 and the check port never requests recovery.
- R2: A write with wr_exc_i = 2'b00 and no poisoned source stores wr_data_i with a clear tag; a later read returns that data with poison 0.
- R3: A speculative write (wr_spec_i = 1) with a fatal class (wr_exc_i[1] = 1) does not assert fault_o; it stores poison 1 with data 0.
- R4: A write with the resumable class (wr_exc_i = 2'b01) asserts pgflt_o in that cycle, leaves the register's data and tag unchanged, and pgflt_o is never high without wr_en_i.
- R5: A read with rd_en_i set and rd_spec_i clear on a poisoned register asserts fault_o in that cycle; the same read with rd_spec_i set leaves fault_o low and still reports rd_poison_o = 1.
- R6: A speculative write with wr_src_poison_i = 1 and no exception stores poison 1 with data 0.
- R7: recover_o equals chk_en_i AND the poison tag of the register at chk_addr_i.
- R8: Register 0 always reads data 0 with poison 0; writes to it of any class, speculative or not, have no effect on it.
- R9: A committing write is forwarded in the same cycle to every read and check port that addresses the same register, with both its new data and its new tag.
- R10: A non-speculative write with a fatal class (wr_exc_i = 2'b10 or 2'b11) asserts fault_o in that cycle and leaves the register unchanged.
- R11: A clean write to a poisoned register clears its tag in the same edge that stores the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | AW | Destination register |
| wr_data_i | input | DW | Result data |
| wr_spec_i | input | 1 | Producing instruction is speculative |
| wr_exc_i | input | 2 | Fault class: 00 none, 01 resumable, 1x fatal |
| wr_src_poison_i | input | 1 | A source of the producing instruction was poisoned |
| rd_en_i | input | NRD | Read valid per port |
| rd_spec_i | input | NRD | Reader is speculative, per port |
| rd_addr_i | input | NRD x AW | Read address per port |
| rd_data_o | output | NRD x DW | Read data per port |
| rd_poison_o | output | NRD | Poison tag per port |
| chk_en_i | input | 1 | Check operation valid |
| chk_addr_i | input | AW | Register tested by the check |
| recover_o | output | 1 | Recovery request from the check |
| fault_o | output | 1 | Fatal fault to be taken now |
| pgflt_o | output | 1 | Resumable fault to be serviced |

## Verification
The assertions take the write-port inputs as one coherent instruction: the class, speculative flag and source-poison bit are read only when wr_en_i is high. They also take the read-port speculative flags as meaningful only under rd_en_i, and the address ranges as within NREG. The stimulus holds every enable low outside the cycles it means to issue and uses only addresses below 16. It changes all inputs at the falling edge, so each property sees one stable instruction per cycle.

// File: rtl/poison_rf_pkg.sv
package poison_rf_pkg;

  typedef enum logic [1:0] {
    EXC_NONE   = 2'b00,
    EXC_RESUME = 2'b01,
    EXC_FATAL  = 2'b10,
    EXC_FATAL2 = 2'b11
  } exc_class_e;

  typedef struct packed {
    logic commit;     // register state changes this edge
    logic poison;     // tag value to store
    logic fatal_now;  // non-speculative fatal fault
    logic resume;     // resumable fault to service
  } wr_dec_t;

  function automatic logic is_fatal(exc_class_e c);
    return (c == EXC_FATAL) || (c == EXC_FATAL2);
  endfunction

endpackage

// File: rtl/poison_rf_wrclass.sv
module poison_rf_wrclass
  import poison_rf_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_spec_i,
  input  logic [1:0]    wr_exc_i,
  input  logic          wr_src_poison_i,
  output wr_dec_t       dec_o
);

  exc_class_e cls;
  logic       fatal_cls;

  always_comb begin
    cls             = exc_class_e'(wr_exc_i);
    fatal_cls       = is_fatal(cls);
    dec_o.resume    = wr_en_i && (cls == EXC_RESUME);
    dec_o.fatal_now = wr_en_i && fatal_cls && !wr_spec_i;
    dec_o.poison    = wr_spec_i && (fatal_cls || wr_src_poison_i);
    dec_o.commit    = wr_en_i && (wr_addr_i != '0)
                      && !dec_o.resume && !dec_o.fatal_now;
  end

endmodule

// File: rtl/poison_rf_store.sv
module poison_rf_store #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             waddr_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic                      wpoison_i,
  output logic [NREG-1:0][DW-1:0]   data_o,
  output logic [NREG-1:0]           tag_o
);

  logic [NREG-1:1][DW-1:0] mem_q;
  logic [NREG-1:1]         tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      tag_q <= '0;
    end else if (we_i) begin
      for (int i = 1; i < NREG; i++) begin
        if (waddr_i == AW'(i)) begin
          mem_q[i] <= wdata_i;
          tag_q[i] <= wpoison_i;
        end
      end
    end
  end

  // entry 0 is a constant clean zero
  always_comb begin
    data_o[0] = '0;
    tag_o[0]  = 1'b0;
    for (int i = 1; i < NREG; i++) begin
      data_o[i] = mem_q[i];
      tag_o[i]  = tag_q[i];
    end
  end

endmodule

// File: rtl/poison_rf_port.sv
module poison_rf_port #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 4
) (
  input  logic [AW-1:0]           addr_i,
  input  logic [NREG-1:0][DW-1:0] data_i,
  input  logic [NREG-1:0]         tag_i,
  input  logic                    byp_we_i,
  input  logic [AW-1:0]           byp_addr_i,
  input  logic [DW-1:0]           byp_data_i,
  input  logic                    byp_poison_i,
  output logic [DW-1:0]           data_o,
  output logic                    poison_o
);

  logic hit;

  always_comb begin
    hit = byp_we_i && (byp_addr_i == addr_i);
    if (addr_i == '0) begin
      data_o   = '0;
      poison_o = 1'b0;
    end else if (hit) begin
      data_o   = byp_data_i;
      poison_o = byp_poison_i;
    end else begin
      data_o   = data_i[addr_i];
      poison_o = tag_i[addr_i];
    end
  end

endmodule

// File: rtl/poison_rf.sv
module poison_rf
  import poison_rf_pkg::*;
#(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned NRD  = 2,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic                     wr_spec_i,
  input  logic [1:0]               wr_exc_i,
  input  logic                     wr_src_poison_i,
  input  logic [NRD-1:0]           rd_en_i,
  input  logic [NRD-1:0]           rd_spec_i,
  input  logic [NRD-1:0][AW-1:0]   rd_addr_i,
  output logic [NRD-1:0][DW-1:0]   rd_data_o,
  output logic [NRD-1:0]           rd_poison_o,
  input  logic                     chk_en_i,
  input  logic [AW-1:0]            chk_addr_i,
  output logic                     recover_o,
  output logic                     fault_o,
  output logic                     pgflt_o
);

  wr_dec_t                 dec;
  logic [DW-1:0]           wdata_eff;
  logic [NREG-1:0][DW-1:0] st_data;
  logic [NREG-1:0]         st_tag;
  logic [DW-1:0]           chk_data_unused;
  logic                    chk_poison;

  poison_rf_wrclass #(.AW(AW)) u_wrclass (
    .wr_en_i         (wr_en_i),
    .wr_addr_i       (wr_addr_i),
    .wr_spec_i       (wr_spec_i),
    .wr_exc_i        (wr_exc_i),
    .wr_src_poison_i (wr_src_poison_i),
    .dec_o           (dec)
  );

  // poisoned results carry no payload
  assign wdata_eff = dec.poison ? '0 : wr_data_i;

  poison_rf_store #(.NREG(NREG), .DW(DW), .AW(AW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (dec.commit),
    .waddr_i   (wr_addr_i),
    .wdata_i   (wdata_eff),
    .wpoison_i (dec.poison),
    .data_o    (st_data),
    .tag_o     (st_tag)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    poison_rf_port #(.NREG(NREG), .DW(DW), .AW(AW)) u_port (
      .addr_i       (rd_addr_i[p]),
      .data_i       (st_data),
      .tag_i        (st_tag),
      .byp_we_i     (dec.commit),
      .byp_addr_i   (wr_addr_i),
      .byp_data_i   (wdata_eff),
      .byp_poison_i (dec.poison),
      .data_o       (rd_data_o[p]),
      .poison_o     (rd_poison_o[p])
    );
  end

  poison_rf_port #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk_port (
    .addr_i       (chk_addr_i),
    .data_i       (st_data),
    .tag_i        (st_tag),
    .byp_we_i     (dec.commit),
    .byp_addr_i   (wr_addr_i),
    .byp_data_i   (wdata_eff),
    .byp_poison_i (dec.poison),
    .data_o       (chk_data_unused),
    .poison_o     (chk_poison)
  );

  assign recover_o = chk_en_i && chk_poison;
  assign fault_o   = (|(rd_en_i & ~rd_spec_i & rd_poison_o)) || dec.fatal_now;
  assign pgflt_o   = dec.resume;

endmodule

// File: rtl/poison_rf_chk.sv
module poison_rf_chk #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned NRD  = 2,
  parameter int unsigned AW   = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic [AW-1:0]          wr_addr_i,
  input logic                   wr_spec_i,
  input logic [1:0]             wr_exc_i,
  input logic [NRD-1:0]         rd_en_i,
  input logic [NRD-1:0]         rd_spec_i,
  input logic [NRD-1:0][AW-1:0] rd_addr_i,
  input logic [NRD-1:0][DW-1:0] rd_data_o,
  input logic [NRD-1:0]         rd_poison_o,
  input logic                   chk_en_i,
  input logic [AW-1:0]          chk_addr_i,
  input logic                   recover_o,
  input logic                   fault_o,
  input logic                   pgflt_o
);

  AST_ZERO_REG_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i[0] == '0) |-> (rd_data_o[0] == '0 && !rd_poison_o[0])); // R8

  AST_RESUME_SIGNALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_exc_i == 2'b01) |-> pgflt_o); // R4

  AST_RESUME_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgflt_o |-> wr_en_i); // R4

  AST_NONSPEC_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_spec_i && wr_exc_i[1]) |-> fault_o); // R10

  AST_RECOVER_NEEDS_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> chk_en_i); // R7

  AST_SPEC_READ_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((rd_en_i & ~rd_spec_i) == '0) && !(wr_en_i && !wr_spec_i && wr_exc_i[1]))
      |-> !fault_o); // R5

  AST_BYPASS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_spec_i && wr_exc_i == 2'b00 && wr_addr_i != '0
     && chk_en_i && chk_addr_i == wr_addr_i) |-> !recover_o); // R9

  AST_CLEAN_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_spec_i && wr_exc_i == 2'b00 && wr_addr_i != '0)
      |=> (!(chk_en_i && chk_addr_i == $past(wr_addr_i) && !wr_en_i) || !recover_o)); // R11

  AST_POISON_PERSISTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_spec_i && wr_exc_i[1] && wr_addr_i != '0)
      |=> (!(chk_en_i && chk_addr_i == $past(wr_addr_i) && !wr_en_i) || recover_o)); // R3

endmodule

bind poison_rf poison_rf_chk #(.NREG(NREG), .DW(DW), .NRD(NRD), .AW(AW)) u_poison_rf_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_spec_i   (wr_spec_i),
  .wr_exc_i    (wr_exc_i),
  .rd_en_i     (rd_en_i),
  .rd_spec_i   (rd_spec_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .rd_poison_o (rd_poison_o),
  .chk_en_i    (chk_en_i),
  .chk_addr_i  (chk_addr_i),
  .recover_o   (recover_o),
  .fault_o     (fault_o),
  .pgflt_o     (pgflt_o)
);

// File: tb/poison_rf_test.sv
`timescale 1ns/1ps
module poison_rf_test;

  localparam int NREG = 16;
  localparam int DW   = 32;
  localparam int NRD  = 2;
  localparam int AW   = 4;

  typedef struct packed {
    logic          en;
    logic [3:0]    addr;
    logic [31:0]   data;
    logic          spec;
    logic [1:0]    exc;
    logic          srcp;
    logic          x_fault;
    logic          x_pg;
    logic [31:0]   x_data;
    logic          x_poi;
  } vec_t;

  localparam int NVEC = 11;
  // each row: write in one cycle, speculative read-back and check in the next
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 4'd3,  32'hA5A5_0001, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 32'hA5A5_0001, 1'b0}, // R2
    '{1'b1, 4'd5,  32'h0000_0011, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 32'h0,         1'b1}, // R3
    '{1'b1, 4'd3,  32'h0000_0022, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 32'hA5A5_0001, 1'b0}, // R4
    '{1'b1, 4'd3,  32'h0000_0033, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 32'hA5A5_0001, 1'b0}, // R10
    '{1'b1, 4'd7,  32'h0000_0044, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 32'h0,         1'b1}, // R6
    '{1'b1, 4'd5,  32'h0000_0055, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 32'h0000_0055, 1'b0}, // R11
    '{1'b1, 4'd0,  32'h0000_0066, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0}, // R8
    '{1'b1, 4'd0,  32'h0000_0077, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0}, // R8
    '{1'b1, 4'd9,  32'h0000_0099, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 32'h0000_0099, 1'b0}, // R2
    '{1'b1, 4'd7,  32'h0000_0088, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 32'h0,         1'b1}, // R4
    '{1'b1, 4'd2,  32'h0000_0012, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 32'h0,         1'b0}  // R10
  };

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   wr_en_i = 1'b0;
  logic [AW-1:0]          wr_addr_i = '0;
  logic [DW-1:0]          wr_data_i = '0;
  logic                   wr_spec_i = 1'b0;
  logic [1:0]             wr_exc_i = '0;
  logic                   wr_src_poison_i = 1'b0;
  logic [NRD-1:0]         rd_en_i = '0;
  logic [NRD-1:0]         rd_spec_i = '0;
  logic [NRD-1:0][AW-1:0] rd_addr_i = '0;
  logic [NRD-1:0][DW-1:0] rd_data_o;
  logic [NRD-1:0]         rd_poison_o;
  logic                   chk_en_i = 1'b0;
  logic [AW-1:0]          chk_addr_i = '0;
  logic                   recover_o, fault_o, pgflt_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  poison_rf #(.NREG(NREG), .DW(DW), .NRD(NRD)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = 1'b0; wr_spec_i = 1'b0; wr_exc_i = 2'b00; wr_src_poison_i = 1'b0;
    rd_en_i = '0; rd_spec_i = '0; chk_en_i = 1'b0;
  endtask

  task automatic drive_wr(input logic [3:0] a, input logic [31:0] d, input logic s,
                          input logic [1:0] e, input logic sp);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; wr_spec_i = s;
    wr_exc_i = e; wr_src_poison_i = sp;
  endtask

  initial begin
    repeat (4000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: clean state after reset
    @(negedge clk_i);
    rd_en_i = 2'b01; rd_spec_i = 2'b01; rd_addr_i[0] = 4'd5;
    chk_en_i = 1'b1; chk_addr_i = 4'd5;
    #8;
    check("R1 data", rd_data_o[0], 32'h0);
    check("R1 poison", {31'b0, rd_poison_o[0]}, 32'h0);
    check("R1 recover", {31'b0, recover_o}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = TBL[i];
      @(negedge clk_i);
      idle();
      drive_wr(v.addr, v.data, v.spec, v.exc, v.srcp);
      #8;
      check($sformatf("R10/R3 fault row %0d", i), {31'b0, fault_o}, {31'b0, v.x_fault});
      check($sformatf("R4 pgflt row %0d", i), {31'b0, pgflt_o}, {31'b0, v.x_pg});
      @(negedge clk_i);
      idle();
      rd_en_i = 2'b01; rd_spec_i = 2'b01; rd_addr_i[0] = v.addr;
      chk_en_i = 1'b1; chk_addr_i = v.addr;
      #8;
      check($sformatf("R2 data row %0d", i), rd_data_o[0], v.x_data);
      check($sformatf("R6 poison row %0d", i), {31'b0, rd_poison_o[0]}, {31'b0, v.x_poi});
      check($sformatf("R7 recover row %0d", i), {31'b0, recover_o}, {31'b0, v.x_poi});
    end

    // R5: non-speculative read of poisoned r7 faults; speculative does not
    @(negedge clk_i);
    idle();
    rd_en_i = 2'b10; rd_spec_i = 2'b00; rd_addr_i[1] = 4'd7;
    #8;
    check("R5 nonspec fault", {31'b0, fault_o}, 32'h1);
    check("R5 nonspec poison", {31'b0, rd_poison_o[1]}, 32'h1);
    @(negedge clk_i);
    rd_en_i = 2'b10; rd_spec_i = 2'b10; rd_addr_i[1] = 4'd7;
    #8;
    check("R5 spec no fault", {31'b0, fault_o}, 32'h0);
    check("R5 spec poison", {31'b0, rd_poison_o[1]}, 32'h1);
    @(negedge clk_i);
    rd_en_i = 2'b10; rd_spec_i = 2'b00; rd_addr_i[1] = 4'd9;
    #8;
    check("R5 clean no fault", {31'b0, fault_o}, 32'h0);

    // R7: check disabled on poisoned register
    @(negedge clk_i);
    idle();
    chk_en_i = 1'b0; chk_addr_i = 4'd7;
    #8;
    check("R7 chk off", {31'b0, recover_o}, 32'h0);

    // R9: same-cycle forwarding of clean data
    @(negedge clk_i);
    idle();
    drive_wr(4'd11, 32'hABCD_0123, 1'b0, 2'b00, 1'b0);
    rd_en_i = 2'b01; rd_spec_i = 2'b01; rd_addr_i[0] = 4'd11;
    #8;
    check("R9 bypass data", rd_data_o[0], 32'hABCD_0123);
    check("R9 bypass poison", {31'b0, rd_poison_o[0]}, 32'h0);

    // R9: same-cycle forwarding of poison
    @(negedge clk_i);
    idle();
    drive_wr(4'd12, 32'h0000_5555, 1'b1, 2'b10, 1'b0);
    chk_en_i = 1'b1; chk_addr_i = 4'd12;
    rd_en_i = 2'b10; rd_spec_i = 2'b10; rd_addr_i[1] = 4'd12;
    #8;
    check("R9 bypass recover", {31'b0, recover_o}, 32'h1);
    check("R9 bypass poison", {31'b0, rd_poison_o[1]}, 32'h1);
    check("R9 bypass zero data", rd_data_o[1], 32'h0);

    // R11: clean write over poisoned r12, forwarded clear tag
    @(negedge clk_i);
    idle();
    drive_wr(4'd12, 32'h0000_6666, 1'b0, 2'b00, 1'b0);
    chk_en_i = 1'b1; chk_addr_i = 4'd12;
    #8;
    check("R11 clear same cycle", {31'b0, recover_o}, 32'h0);
    @(negedge clk_i);
    idle();
    rd_en_i = 2'b01; rd_spec_i = 2'b01; rd_addr_i[0] = 4'd12;
    #8;
    check("R11 data", rd_data_o[0], 32'h0000_6666);
    check("R11 poison", {31'b0, rd_poison_o[0]}, 32'h0);

    // R1: asynchronous reset mid-run clears poisoned r7 and data of r3
    @(negedge clk_i);
    idle();
    rst_ni = 1'b0;
    chk_en_i = 1'b1; chk_addr_i = 4'd7;
    rd_en_i = 2'b01; rd_spec_i = 2'b01; rd_addr_i[0] = 4'd3;
    #5;
    check("R1 reset recover", {31'b0, recover_o}, 32'h0);
    check("R1 reset data", rd_data_o[0], 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule